// File: doc/BRIEF.md
# Host-Coprocessor Mailbox and Watchdog Register Block

This block holds the small set of control and signalling registers that sit between a host CPU and a control coprocessor. The host reaches them over a plain 32-bit register bus: address, write strobe, write data, and combinational read data. The coprocessor side sees the doorbell level, a run/reset level, a watchdog enable and a timer-interrupt mask. It drives back a doorbell-consumed pulse, a message-raise pulse, a watchdog-expire pulse and an idle level.

The host posts a command by setting the doorbell. The bit stays set until the coprocessor consumes it, so the host polls for zero before it posts again. In the other direction, one interrupt register carries either a message code or a watchdog code. A level interrupt to the host is active while that register is nonzero. Once an event is latched, later events are dropped until the host writes zero back. The shared message memory, the processor core and any clock gating are outside this block.

Top module: `cpmbox_top`

## Requirements
- R1: Writing a value with bit 0 set to offset 0x24 while the doorbell is clear sets the doorbell. `cp_doorbell` and bit 0 of a read at 0x24 show 1 from the next cycle. A write with bit 0 clear has no effect.
- R2: A `cp_consume` pulse while the doorbell is set clears it on the next cycle. A `cp_consume` pulse while the doorbell is clear has no effect.
- R3: A host write of 1 to 0x24 while the doorbell is already set is ignored. After the next consume the doorbell reads 0 and stays 0.
- R4: The interrupt register at offset 0x1C loads 0x00000100 (bit 8, message pending) on `cp_ipc_raise`. It loads 0x00000001 (watchdog code) on `cp_wdt_expire`. When both arrive in the same cycle the message code wins. `host_irq` is 1 exactly while the register is nonzero.
- R5: A raise or expire pulse that arrives while the interrupt register is nonzero is dropped, and the register keeps its value.
- R6: A host write of the value 0 to 0x1C clears the interrupt register on the next cycle, and this takes priority over a raise in the same cycle. Host writes of nonzero values to 0x1C are ignored.
- R7: Bit 31 of offset 0x84 is the watchdog enable. It is readable and drives `cp_wdt_en`. While it is 0, `cp_wdt_expire` has no effect.
- R8: Bit 23 of offset 0x34 is the coprocessor timer-interrupt mask. It is readable and writable and drives `cp_tmr_mask`.
- R9: A read at offset 0x2C returns `cp_idle` in bit 0, in the same cycle.
- R10: Bit 0 of offset 0x00 is the run control. Writing 0 holds the coprocessor in reset and writing 1 releases it. It drives `cp_run` and reads back in bit 0.
- R11: After reset every register and output is 0 except the idle reading. Reads of unmapped offsets return 0, and bits outside the defined fields read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (8) | Host byte offset |
| bus_wr | input | 1 | Host write strobe |
| bus_wdata | input | DATA_W (32) | Host write data |
| bus_rdata | output | DATA_W (32) | Host read data for `bus_addr` |
| cp_consume | input | 1 | Coprocessor has taken the doorbell command |
| cp_ipc_raise | input | 1 | Coprocessor requests a message interrupt |
| cp_wdt_expire | input | 1 | Coprocessor watchdog has expired |
| cp_idle | input | 1 | Coprocessor is idle |
| cp_doorbell | output | 1 | Doorbell pending level |
| cp_run | output | 1 | 1 releases the coprocessor from reset |
| cp_wdt_en | output | 1 | Watchdog enable |
| cp_tmr_mask | output | 1 | Coprocessor timer interrupt mask |
| host_irq | output | 1 | Level interrupt to the host |

## Verification
The assertions assume that the coprocessor pulses and the host strobe are single-cycle synchronous levels sampled at the rising edge. They also assume that `bus_addr` is stable at that edge. The stimulus drives every input at the falling edge, holds it for one full cycle, and reselects all of them on each step.

Random steps mix writes to mapped and unmapped offsets. Half of the writes aimed at the interrupt register carry zero, so clears compete with raises often. Directed steps first force the specific orderings: a repeat post on a set doorbell, an expire while the watchdog is disabled, and a raise into a full interrupt register.

// File: rtl/cpmbox_pkg.sv
package cpmbox_pkg;
   localparam logic [7:0] OFS_RUN   = 8'h00;
   localparam logic [7:0] OFS_C2H   = 8'h1C;
   localparam logic [7:0] OFS_DBELL = 8'h24;
   localparam logic [7:0] OFS_IDLE  = 8'h2C;
   localparam logic [7:0] OFS_MASK  = 8'h34;
   localparam logic [7:0] OFS_WDT   = 8'h84;

   localparam int MSG_BIT  = 8;
   localparam int MASK_BIT = 23;
   localparam int WDT_BIT  = 31;

   typedef struct packed {
      logic run;
      logic wdt_en;
      logic tmr_mask;
   } ctrl_t;
endpackage

// File: rtl/cpmbox_doorbell.sv
module cpmbox_doorbell (
   input  logic clk,
   input  logic rst_n,
   input  logic post,
   input  logic consume,
   output logic pending
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  pending <= 1'b0;
      else if (pending && consume) pending <= 1'b0;
      else if (!pending && post)   pending <= 1'b1;
   end

   p_post_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (post && !pending) |=> pending);
   p_consume_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (pending && consume) |=> !pending);
   p_repost_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (pending && !consume) |=> pending);
   p_idle_consume_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!pending && !post) |=> !pending);
endmodule

// File: rtl/cpmbox_c2h.sv
module cpmbox_c2h #(
   parameter int DATA_W   = 32,
   parameter int MSG_BIT  = 8,
   parameter int WDT_CODE = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_clr,
   input  logic              ipc_raise,
   input  logic              wdt_expire,
   input  logic              wdt_en,
   output logic [DATA_W-1:0] value
);
   localparam logic [DATA_W-1:0] MSG_CODE = DATA_W'(1) << MSG_BIT;
   localparam logic [DATA_W-1:0] WDT_VAL  = DATA_W'(WDT_CODE);

   logic wdt_evt;
   assign wdt_evt = wdt_expire && wdt_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             value <= '0;
      else if (host_clr)      value <= '0;
      else if (value == '0) begin
         if (ipc_raise)       value <= MSG_CODE;
         else if (wdt_evt)    value <= WDT_VAL;
      end
   end

   p_raise_loads_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!host_clr && value == '0 && ipc_raise) |=> value == MSG_CODE);
   p_expire_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!wdt_en && !ipc_raise && value == '0) |=> value == '0);
   p_hold_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (value != '0 && !host_clr) |=> $stable(value));
   p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      host_clr |=> value == '0);
endmodule

// File: rtl/cpmbox_ctrl.sv
module cpmbox_ctrl
   import cpmbox_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  wr_run,
   input  logic  wr_wdt,
   input  logic  wr_mask,
   input  ctrl_t wdata,
   output ctrl_t state
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= '0;
      else begin
         if (wr_run)  state.run      <= wdata.run;
         if (wr_wdt)  state.wdt_en   <= wdata.wdt_en;
         if (wr_mask) state.tmr_mask <= wdata.tmr_mask;
      end
   end

   p_wdt_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_wdt |=> state.wdt_en == $past(wdata.wdt_en));
   p_mask_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_mask |=> state.tmr_mask == $past(wdata.tmr_mask));
   p_run_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_run |=> $stable(state.run));
endmodule

// File: rtl/cpmbox_top.sv
module cpmbox_top
   import cpmbox_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 32,
   parameter int IDLE_SYNC = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              cp_consume,
   input  logic              cp_ipc_raise,
   input  logic              cp_wdt_expire,
   input  logic              cp_idle,
   output logic              cp_doorbell,
   output logic              cp_run,
   output logic              cp_wdt_en,
   output logic              cp_tmr_mask,
   output logic              host_irq
);
   localparam logic [ADDR_W-1:0] A_RUN   = ADDR_W'(OFS_RUN);
   localparam logic [ADDR_W-1:0] A_C2H   = ADDR_W'(OFS_C2H);
   localparam logic [ADDR_W-1:0] A_DBELL = ADDR_W'(OFS_DBELL);
   localparam logic [ADDR_W-1:0] A_IDLE  = ADDR_W'(OFS_IDLE);
   localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(OFS_MASK);
   localparam logic [ADDR_W-1:0] A_WDT   = ADDR_W'(OFS_WDT);

   if (ADDR_W < 8) begin : g_chk_addr
      $error("cpmbox_top: ADDR_W must be at least 8");
   end
   if (DATA_W < 32) begin : g_chk_data
      $error("cpmbox_top: DATA_W must be at least 32");
   end
   if (IDLE_SYNC == 1 || IDLE_SYNC < 0) begin : g_chk_sync
      $error("cpmbox_top: IDLE_SYNC must be 0 or at least 2");
   end

   logic idle_q;
   if (IDLE_SYNC == 0) begin : g_idle_direct
      assign idle_q = cp_idle;
   end else begin : g_idle_sync
      logic [IDLE_SYNC-1:0] sh;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh <= '0;
         else begin
            sh[0] <= cp_idle;
            for (int i = 1; i < IDLE_SYNC; i++) sh[i] <= sh[i-1];
         end
      end
      assign idle_q = sh[IDLE_SYNC-1];
   end

   logic sel_run, sel_c2h, sel_dbell, sel_idle, sel_mask, sel_wdt, mapped;
   always_comb begin
      sel_run   = (bus_addr == A_RUN);
      sel_c2h   = (bus_addr == A_C2H);
      sel_dbell = (bus_addr == A_DBELL);
      sel_idle  = (bus_addr == A_IDLE);
      sel_mask  = (bus_addr == A_MASK);
      sel_wdt   = (bus_addr == A_WDT);
      mapped    = sel_run | sel_c2h | sel_dbell | sel_idle | sel_mask | sel_wdt;
   end

   logic db_pending;
   cpmbox_doorbell u_dbell (
      .clk     (clk),
      .rst_n   (rst_n),
      .post    (bus_wr && sel_dbell && bus_wdata[0]),
      .consume (cp_consume),
      .pending (db_pending)
   );

   ctrl_t ctrl_q, ctrl_d;
   assign ctrl_d = '{run: bus_wdata[0], wdt_en: bus_wdata[WDT_BIT],
                     tmr_mask: bus_wdata[MASK_BIT]};
   cpmbox_ctrl u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_run  (bus_wr && sel_run),
      .wr_wdt  (bus_wr && sel_wdt),
      .wr_mask (bus_wr && sel_mask),
      .wdata   (ctrl_d),
      .state   (ctrl_q)
   );

   logic [DATA_W-1:0] c2h_q;
   cpmbox_c2h #(.DATA_W(DATA_W), .MSG_BIT(MSG_BIT), .WDT_CODE(1)) u_c2h (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_clr   (bus_wr && sel_c2h && bus_wdata == '0),
      .ipc_raise  (cp_ipc_raise),
      .wdt_expire (cp_wdt_expire),
      .wdt_en     (ctrl_q.wdt_en),
      .value      (c2h_q)
   );

   always_comb begin
      bus_rdata = '0;
      if (sel_run)   bus_rdata[0]        = ctrl_q.run;
      if (sel_c2h)   bus_rdata           = c2h_q;
      if (sel_dbell) bus_rdata[0]        = db_pending;
      if (sel_idle)  bus_rdata[0]        = idle_q;
      if (sel_mask)  bus_rdata[MASK_BIT] = ctrl_q.tmr_mask;
      if (sel_wdt)   bus_rdata[WDT_BIT]  = ctrl_q.wdt_en;
   end

   assign cp_doorbell = db_pending;
   assign cp_run      = ctrl_q.run;
   assign cp_wdt_en   = ctrl_q.wdt_en;
   assign cp_tmr_mask = ctrl_q.tmr_mask;
   assign host_irq    = |c2h_q;

   p_irq_matches_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
      sel_c2h |-> (host_irq == (bus_rdata != '0)));
   p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !mapped |-> bus_rdata == '0);
   p_dbell_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
      sel_dbell |-> bus_rdata[0] == cp_doorbell);
endmodule

// File: tb/tb_cpmbox_top.sv
module tb_cpmbox_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic cp_consume = 0, cp_ipc_raise = 0, cp_wdt_expire = 0, cp_idle = 0;
   logic cp_doorbell, cp_run, cp_wdt_en, cp_tmr_mask, host_irq;

   always #(CLK_PERIOD/2) clk = ~clk;

   cpmbox_top dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cp_consume(cp_consume),
      .cp_ipc_raise(cp_ipc_raise), .cp_wdt_expire(cp_wdt_expire),
      .cp_idle(cp_idle), .cp_doorbell(cp_doorbell), .cp_run(cp_run),
      .cp_wdt_en(cp_wdt_en), .cp_tmr_mask(cp_tmr_mask), .host_irq(host_irq)
   );

   int checks = 0, fails = 0;
   bit done = 0;

   bit m_db, m_run, m_wdt, m_mask;
   logic [31:0] m_c2h;

   function automatic logic [31:0] exp_read(logic [7:0] a, bit idl);
      logic [31:0] r = '0;
      case (a)
         8'h00: r[0]  = m_run;
         8'h1C: r     = m_c2h;
         8'h24: r[0]  = m_db;
         8'h2C: r[0]  = idl;
         8'h34: r[23] = m_mask;
         8'h84: r[31] = m_wdt;
         default: r = '0;
      endcase
      return r;
   endfunction

   function automatic string req_of(logic [7:0] a);
      case (a)
         8'h00: return "R10 run read";
         8'h1C: return "R6 irq reg read";
         8'h24: return "R1 doorbell read";
         8'h2C: return "R9 idle read";
         8'h34: return "R8 mask read";
         8'h84: return "R7 wdt read";
         default: return "R11 unmapped read";
      endcase
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step(bit wr, logic [7:0] a, logic [31:0] d,
                       bit cons, bit ipc, bit ex, bit idl);
      bit n_db;
      logic [31:0] n_c2h;
      bus_wr = wr; bus_addr = a; bus_wdata = d;
      cp_consume = cons; cp_ipc_raise = ipc; cp_wdt_expire = ex; cp_idle = idl;
      n_db = m_db;
      if (m_db && cons) n_db = 0;
      else if (!m_db && wr && a == 8'h24 && d[0]) n_db = 1;
      n_c2h = m_c2h;
      if (wr && a == 8'h1C && d == 0) n_c2h = 0;
      else if (m_c2h == 0) begin
         if (ipc) n_c2h = 32'h100;
         else if (ex && m_wdt) n_c2h = 32'h1;
      end
      @(posedge clk);
      m_db = n_db; m_c2h = n_c2h;
      if (wr && a == 8'h00) m_run  = d[0];
      if (wr && a == 8'h84) m_wdt  = d[31];
      if (wr && a == 8'h34) m_mask = d[23];
      @(negedge clk);
      chk("R1 doorbell port", cp_doorbell, m_db);
      chk("R4 host_irq", host_irq, m_c2h != 0);
      chk("R10 run port", cp_run, m_run);
      chk("R7 wdt port", cp_wdt_en, m_wdt);
      chk("R8 mask port", cp_tmr_mask, m_mask);
      chk(req_of(a), bus_rdata, exp_read(a, idl));
   endtask

   task automatic rd(logic [7:0] a, bit idl);
      step(0, a, 0, 0, 0, 0, idl);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [7:0] addrs [8];
      addrs = '{8'h00, 8'h1C, 8'h24, 8'h2C, 8'h34, 8'h84, 8'h40, 8'h90};
      void'($urandom(32'd1234));
      m_db = 0; m_run = 0; m_wdt = 0; m_mask = 0; m_c2h = 0;
      repeat (3) @(negedge clk);
      // R11 reset state
      chk("R11 reset doorbell", cp_doorbell, 0);
      chk("R11 reset irq", host_irq, 0);
      chk("R11 reset run", cp_run, 0);
      chk("R11 reset wdt", cp_wdt_en, 0);
      chk("R11 reset mask", cp_tmr_mask, 0);
      rst_n = 1'b1;
      foreach (addrs[i]) rd(addrs[i], 0);

      // R1 / R2 / R3 doorbell
      step(1, 8'h24, 32'hFFFF_FFFE, 0, 0, 0, 0);
      chk("R1 write without bit0", cp_doorbell, 0);
      step(1, 8'h24, 32'h1, 0, 0, 0, 0);
      chk("R1 post", cp_doorbell, 1);
      step(1, 8'h24, 32'h1, 0, 0, 0, 0);
      chk("R3 repost while set", cp_doorbell, 1);
      step(0, 8'h24, 0, 1, 0, 0, 0);
      chk("R2 consume clears", cp_doorbell, 0);
      rd(8'h24, 0);
      chk("R3 not re-armed", bus_rdata, 0);
      step(0, 8'h24, 0, 1, 0, 0, 0);
      chk("R2 consume while clear", cp_doorbell, 0);

      // R7 expire gated while disabled
      step(0, 8'h1C, 0, 0, 0, 1, 0);
      chk("R7 expire ignored when disabled", bus_rdata, 0);
      step(1, 8'h84, 32'h8000_0000, 0, 0, 0, 0);
      step(0, 8'h1C, 0, 0, 0, 1, 0);
      chk("R4 watchdog code", bus_rdata, 32'h1);
      step(0, 8'h1C, 0, 0, 1, 0, 0);
      chk("R5 raise dropped", bus_rdata, 32'h1);
      step(1, 8'h1C, 32'h100, 0, 0, 0, 0);
      chk("R6 nonzero write ignored", bus_rdata, 32'h1);
      step(1, 8'h1C, 32'h0, 0, 1, 0, 0);
      chk("R6 clear beats raise", bus_rdata, 0);
      step(0, 8'h1C, 0, 0, 1, 1, 0);
      chk("R4 message wins", bus_rdata, 32'h100);
      chk("R4 irq level", host_irq, 1);
      step(1, 8'h1C, 32'h0, 0, 0, 0, 0);
      chk("R6 clear", host_irq, 0);

      // R8 / R9 / R10 / R11
      step(1, 8'h34, 32'h0080_0000, 0, 0, 0, 1);
      chk("R8 mask set", cp_tmr_mask, 1);
      rd(8'h2C, 1);
      chk("R9 idle high", bus_rdata, 32'h1);
      step(1, 8'h00, 32'h1, 0, 0, 0, 0);
      chk("R10 run release", cp_run, 1);
      step(1, 8'h40, 32'hFFFF_FFFF, 0, 0, 0, 1);
      chk("R11 unmapped read", bus_rdata, 0);
      step(1, 8'h00, 32'hFFFF_FFFE, 0, 0, 0, 0);
      chk("R10 hold in reset", cp_run, 0);

      // constrained random
      for (int n = 0; n < 3000; n++) begin
         logic [7:0]  a = addrs[$urandom_range(0, 7)];
         logic [31:0] d = $urandom();
         if (a == 8'h1C && $urandom_range(0, 1) == 0) d = 0;
         step($urandom_range(0, 1) == 1, a, d,
              $urandom_range(0, 9) < 3, $urandom_range(0, 9) < 2,
              $urandom_range(0, 9) < 2, $urandom_range(0, 1) == 1);
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule